// File: doc/BRIEF.md
# Effective Address Generator

This block computes, in a single combinational pass, every address that a 16-bit word-addressed processor needs for its next program counter and for its memory address register. It takes the current instruction word, the program counter after its increment, the value of the base register that the instruction names, the word currently on the shared data bus, and the three condition flags. From these it produces the address adder result, the next program counter and the memory address, together with the two selector codes it chose.

There are four offset forms, and one adder is shared between them. The 6-bit form is sign-extended and added to the base register, for register-relative loads and stores. The 9-bit form is sign-extended and added to the incremented PC, for direct, indirect, load-address and branch instructions. The 11-bit form is sign-extended and added to the incremented PC, for the PC-relative subroutine call. The zero offset is added to the base register, for register jumps and register calls. An 8-bit trap vector, zero-extended, goes to the memory address path only.

The next-PC selector chooses one of three sources: the incremented PC, the adder result, or the bus word. The memory-address selector chooses between the adder result and the trap vector. Reading memory and reading the register file are done elsewhere. The adder result is also presented as a port, so that a load-address instruction can write it to a register without any memory access.

Top module: `eag_top`

## Requirements
- R1: For opcodes 0000, 0010, 0011, 1010, 1011 and 1110, `ea_sum` equals `pc_inc` plus `instr[8:0]` sign-extended. `mar_addr` equals `ea_sum`. Relative to `pc_inc`, the reach is -256 to +255.
- R2: For opcodes 0110 and 0111, `ea_sum` equals `base_val` plus `instr[5:0]` sign-extended, which gives an offset range of -32 to +31. `mar_addr` equals `ea_sum`, and `pc_next` equals `pc_inc` with `pc_src` = 2'b00.
- R3: For opcode 0100 with `instr[11]` = 1, `ea_sum` equals `pc_inc` plus `instr[10:0]` sign-extended. `pc_next` equals `ea_sum`, with `pc_src` = 2'b01.
- R4: For opcode 1100, and for opcode 0100 with `instr[11]` = 0, `ea_sum` equals `base_val`, which is a zero offset. `pc_next` equals `base_val`, with `pc_src` = 2'b01.
- R5: For opcode 1111, `mar_addr` equals `{8'h00, instr[7:0]}` with `mar_src` = 1. `pc_next` equals `bus_val`, with `pc_src` = 2'b10.
- R6: For opcode 0000, the branch is taken when `instr[11:9] & cc_nzp` is nonzero. `cc_nzp` holds the flags in the order bit 2 = negative, bit 1 = zero, bit 0 = positive. A taken branch gives `pc_next` = `ea_sum` with `pc_src` = 2'b01. A branch that is not taken gives `pc_next` = `pc_inc` with `pc_src` = 2'b00. A branch whose condition field is 000 is never taken.
- R7: For opcode 1000, `pc_next` equals `bus_val`, with `pc_src` = 2'b10.
- R8: For opcodes 0001, 0010, 0011, 0101, 1001, 1010, 1011, 1101 and 1110, `pc_next` equals `pc_inc`, with `pc_src` = 2'b00.
- R9: Every addition wraps modulo 2^16.
- R10: `mar_src` is 0 for every opcode except 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Current instruction word; opcode in bits [15:12] |
| pc_inc | input | 16 | Program counter after its increment |
| base_val | input | 16 | Value of the base register named by bits [8:6] |
| bus_val | input | 16 | Word on the shared bus (memory-supplied PC for trap and return) |
| cc_nzp | input | 3 | Condition flags: [2] negative, [1] zero, [0] positive |
| ea_sum | output | 16 | Address adder result |
| pc_next | output | 16 | Selected next program counter |
| pc_src | output | 2 | Next-PC source: 00 incremented, 01 adder, 10 bus |
| mar_addr | output | 16 | Selected memory address |
| mar_src | output | 1 | Memory address source: 0 adder, 1 trap vector |

## Verification
There are no registers, so a wrong decode or a wrong extension shows at the ports on the very vector that triggers it. One example is an offset field that is extended from the wrong bit. Another is a branch condition that is tested against the wrong flag. In both cases the error appears as a wrong `ea_sum`, `pc_next` or selector code, and nothing hides it behind a later cycle. The bench therefore pairs each vector with an expected result computed from the opcode rules. It drives boundary offsets and wrapping PCs, and it also drives every branch condition against every flag value.

// File: rtl/eag_pkg.sv
// Package: shared opcode values and selector encodings for the effective
// address generator. Assumes a 4-bit opcode in the top bits of the word.
package eag_pkg;

    typedef enum logic [3:0] {
        OP_BR   = 4'b0000,
        OP_ADD  = 4'b0001,
        OP_LD   = 4'b0010,
        OP_ST   = 4'b0011,
        OP_JSR  = 4'b0100,
        OP_AND  = 4'b0101,
        OP_LDR  = 4'b0110,
        OP_STR  = 4'b0111,
        OP_RTI  = 4'b1000,
        OP_NOT  = 4'b1001,
        OP_LDI  = 4'b1010,
        OP_STI  = 4'b1011,
        OP_JMP  = 4'b1100,
        OP_RSV  = 4'b1101,
        OP_LEA  = 4'b1110,
        OP_TRAP = 4'b1111
    } opcode_e;

    // Next-PC source; encoding is visible on the pc_src port.
    typedef enum logic [1:0] {
        PCS_INC   = 2'b00,
        PCS_ADDER = 2'b01,
        PCS_BUS   = 2'b10
    } pc_src_e;

    // Memory address source; encoding is visible on the mar_src port.
    typedef enum logic {
        MARS_ADDER = 1'b0,
        MARS_VECT  = 1'b1
    } mar_src_e;

    // Offset operand of the address adder.
    typedef enum logic [1:0] {
        OFS_ZERO = 2'd0,
        OFS_S6   = 2'd1,
        OFS_S9   = 2'd2,
        OFS_S11  = 2'd3
    } ofs_sel_e;

    // Base operand of the address adder.
    typedef enum logic {
        BAS_PC  = 1'b0,
        BAS_REG = 1'b1
    } bas_sel_e;

endpackage

// File: rtl/eag_field_ext.sv
// Module: eag_field_ext
// Widens an instruction field to the word width, either by replicating its
// top bit (SIGN_EXT = 1) or by padding with zeros (SIGN_EXT = 0).
// Assumes OUT_W > IN_W.
module eag_field_ext #(
    parameter int IN_W     = 9,
    parameter int OUT_W    = 16,
    parameter bit SIGN_EXT = 1'b1
) (
    input  logic [IN_W-1:0]  field_in,
    output logic [OUT_W-1:0] wide_out
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (SIGN_EXT) begin : g_signed
            // Replicate the field's sign bit into the upper bits.
            always_comb wide_out = {{PAD_W{field_in[IN_W-1]}}, field_in};
        end else begin : g_unsigned
            // Pad the upper bits with zeros.
            always_comb wide_out = {{PAD_W{1'b0}}, field_in};
        end
    endgenerate

endmodule

// File: rtl/eag_decode.sv
// Module: eag_decode
// Turns the opcode, the call-mode bit, the branch condition field and the
// current flags into adder operand selects and the two path selects.
// Assumes the flags are one of the legal codes or zero; any overlap with the
// condition field takes the branch.
module eag_decode
    import eag_pkg::*;
#(
    parameter int OPC_W = 4,
    parameter int CC_W  = 3
) (
    input  logic [OPC_W-1:0] opcode,
    input  logic             call_pcrel,
    input  logic [CC_W-1:0]  br_cond,
    input  logic [CC_W-1:0]  cc_flags,
    output bas_sel_e         bas_sel,
    output ofs_sel_e         ofs_sel,
    output pc_src_e          pc_src,
    output mar_src_e         mar_src
);
    logic br_taken;

    // Branch condition: any requested flag that is currently set.
    always_comb br_taken = |(br_cond & cc_flags);

    // Adder operand selection per instruction class.
    always_comb begin
        bas_sel = BAS_PC;
        ofs_sel = OFS_ZERO;
        unique case (opcode_e'(opcode))
            OP_BR, OP_LD, OP_ST, OP_LDI, OP_STI, OP_LEA: begin
                bas_sel = BAS_PC;
                ofs_sel = OFS_S9;
            end
            OP_LDR, OP_STR: begin
                bas_sel = BAS_REG;
                ofs_sel = OFS_S6;
            end
            OP_JSR: begin
                bas_sel = call_pcrel ? BAS_PC  : BAS_REG;
                ofs_sel = call_pcrel ? OFS_S11 : OFS_ZERO;
            end
            OP_JMP: begin
                bas_sel = BAS_REG;
                ofs_sel = OFS_ZERO;
            end
            default: begin
                bas_sel = BAS_PC;
                ofs_sel = OFS_ZERO;
            end
        endcase
    end

    // Next-PC source per instruction class.
    always_comb begin
        unique case (opcode_e'(opcode))
            OP_BR:           pc_src = br_taken ? PCS_ADDER : PCS_INC;
            OP_JSR, OP_JMP:  pc_src = PCS_ADDER;
            OP_TRAP, OP_RTI: pc_src = PCS_BUS;
            default:         pc_src = PCS_INC;
        endcase
    end

    // Memory address source: the trap vector only for the trap opcode.
    always_comb mar_src = (opcode_e'(opcode) == OP_TRAP) ? MARS_VECT : MARS_ADDER;

    // Decode consistency checks.
    always_comb begin
        // R6
        br_nocond_chk: assert (!((opcode_e'(opcode) == OP_BR) && (br_cond == '0))
                               || (pc_src == PCS_INC))
            else $error("branch with empty condition field taken");
        // R4
        zero_ofs_jump_chk: assert (!((pc_src == PCS_ADDER) && (ofs_sel == OFS_ZERO))
                                   || (bas_sel == BAS_REG))
            else $error("zero-offset jump not register based");
        // R5
        pc_src_legal_chk: assert (pc_src != pc_src_e'(2'b11))
            else $error("illegal next-PC source code");
    end

endmodule

// File: rtl/eag_addr_adder.sv
// Module: eag_addr_adder
// The single shared address adder. It picks a base (the incremented PC or
// the base register) and an already-widened offset, and adds them modulo
// 2^WORD_W. Assumes its offset inputs are already extended to the full width.
module eag_addr_adder
    import eag_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  bas_sel_e          bas_sel,
    input  ofs_sel_e          ofs_sel,
    input  logic [WORD_W-1:0] pc_inc,
    input  logic [WORD_W-1:0] base_val,
    input  logic [WORD_W-1:0] ofs6_w,
    input  logic [WORD_W-1:0] ofs9_w,
    input  logic [WORD_W-1:0] ofs11_w,
    output logic [WORD_W-1:0] sum
);
    logic [WORD_W-1:0] base_opnd;
    logic [WORD_W-1:0] ofs_opnd;

    // Base operand multiplexer.
    always_comb base_opnd = (bas_sel == BAS_REG) ? base_val : pc_inc;

    // Offset operand multiplexer.
    always_comb begin
        unique case (ofs_sel)
            OFS_S6:  ofs_opnd = ofs6_w;
            OFS_S9:  ofs_opnd = ofs9_w;
            OFS_S11: ofs_opnd = ofs11_w;
            default: ofs_opnd = '0;
        endcase
    end

    // Modular addition; the carry out is discarded.
    always_comb sum = base_opnd + ofs_opnd;

    // Adder checks.
    always_comb begin
        // R4
        zero_ofs_pass_chk: assert (!((bas_sel == BAS_REG) && (ofs_sel == OFS_ZERO))
                                   || (sum == base_val))
            else $error("zero offset altered the base register value");
    end

endmodule

// File: rtl/eag_top.sv
// Module: eag_top
// Effective address generator. It widens the offset fields, forms one adder
// result and drives the next-PC and memory-address multiplexers. It is purely
// combinational. Assumes pc_inc is already incremented and that base_val is
// the register named by instr[8:6].
module eag_top
    import eag_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int OPC_W   = 4,
    parameter int CC_W    = 3,
    parameter int OFS6_W  = 6,
    parameter int OFS9_W  = 9,
    parameter int OFS11_W = 11,
    parameter int VECT_W  = 8
) (
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] pc_inc,
    input  logic [WORD_W-1:0] base_val,
    input  logic [WORD_W-1:0] bus_val,
    input  logic [CC_W-1:0]   cc_nzp,
    output logic [WORD_W-1:0] ea_sum,
    output logic [WORD_W-1:0] pc_next,
    output logic [1:0]        pc_src,
    output logic [WORD_W-1:0] mar_addr,
    output logic              mar_src
);
    localparam int OPC_LSB  = WORD_W - OPC_W;
    localparam int COND_LSB = OPC_LSB - CC_W;
    localparam int CALL_BIT = OFS11_W;

    logic [WORD_W-1:0] ofs6_w, ofs9_w, ofs11_w, vect_w;
    bas_sel_e          bas_sel;
    ofs_sel_e          ofs_sel;
    pc_src_e           pc_sel;
    mar_src_e          mar_sel;

    eag_field_ext #(.IN_W(OFS6_W),  .OUT_W(WORD_W), .SIGN_EXT(1'b1)) u_ext6 (
        .field_in (instr[OFS6_W-1:0]),
        .wide_out (ofs6_w)
    );
    eag_field_ext #(.IN_W(OFS9_W),  .OUT_W(WORD_W), .SIGN_EXT(1'b1)) u_ext9 (
        .field_in (instr[OFS9_W-1:0]),
        .wide_out (ofs9_w)
    );
    eag_field_ext #(.IN_W(OFS11_W), .OUT_W(WORD_W), .SIGN_EXT(1'b1)) u_ext11 (
        .field_in (instr[OFS11_W-1:0]),
        .wide_out (ofs11_w)
    );
    eag_field_ext #(.IN_W(VECT_W),  .OUT_W(WORD_W), .SIGN_EXT(1'b0)) u_extv (
        .field_in (instr[VECT_W-1:0]),
        .wide_out (vect_w)
    );

    eag_decode #(.OPC_W(OPC_W), .CC_W(CC_W)) u_dec (
        .opcode     (instr[WORD_W-1:OPC_LSB]),
        .call_pcrel (instr[CALL_BIT]),
        .br_cond    (instr[OPC_LSB-1:COND_LSB]),
        .cc_flags   (cc_nzp),
        .bas_sel    (bas_sel),
        .ofs_sel    (ofs_sel),
        .pc_src     (pc_sel),
        .mar_src    (mar_sel)
    );

    eag_addr_adder #(.WORD_W(WORD_W)) u_add (
        .bas_sel  (bas_sel),
        .ofs_sel  (ofs_sel),
        .pc_inc   (pc_inc),
        .base_val (base_val),
        .ofs6_w   (ofs6_w),
        .ofs9_w   (ofs9_w),
        .ofs11_w  (ofs11_w),
        .sum      (ea_sum)
    );

    // Next-PC multiplexer over its three sources.
    always_comb begin
        unique case (pc_sel)
            PCS_ADDER: pc_next = ea_sum;
            PCS_BUS:   pc_next = bus_val;
            default:   pc_next = pc_inc;
        endcase
    end

    // Memory-address multiplexer: adder result or trap vector.
    always_comb mar_addr = (mar_sel == MARS_VECT) ? vect_w : ea_sum;

    // Export the selector codes.
    always_comb begin
        pc_src  = pc_sel;
        mar_src = mar_sel;
    end

    // Port-level checks.
    always_comb begin
        // R8
        pc_inc_pass_chk: assert ((pc_src != 2'b00) || (pc_next == pc_inc))
            else $error("incremented PC not forwarded");
        // R7
        bus_pass_chk: assert ((pc_src != 2'b10) || (pc_next == bus_val))
            else $error("bus word not forwarded to PC");
        // R5
        vect_range_chk: assert (!mar_src || (mar_addr[WORD_W-1:VECT_W] == '0))
            else $error("trap vector address outside the vector table");
        // R10
        vect_only_trap_chk: assert (!mar_src || (instr[WORD_W-1:OPC_LSB] == '1))
            else $error("trap vector selected for a non-trap opcode");
    end

endmodule

// File: tb/tb_eag_top.sv
// Bench for eag_top. A driver task computes the expected result from the
// opcode rules and queues it; a monitor pops it at the next rising edge.
module tb_eag_top;

    typedef struct {
        logic [15:0] ea;
        logic [15:0] pcn;
        logic [1:0]  pcs;
        logic [15:0] mar;
        logic        mars;
        bit          chk_ea;
        bit          chk_mar;
        string       tag;
        string       note;
    } exp_t;

    logic        clk = 1'b0;
    logic [15:0] instr = '0, pc_inc = '0, base_val = '0, bus_val = '0;
    logic [2:0]  cc_nzp = '0;
    logic [15:0] ea_sum, pc_next, mar_addr;
    logic [1:0]  pc_src;
    logic        mar_src;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    eag_top dut (
        .instr    (instr),
        .pc_inc   (pc_inc),
        .base_val (base_val),
        .bus_val  (bus_val),
        .cc_nzp   (cc_nzp),
        .ea_sum   (ea_sum),
        .pc_next  (pc_next),
        .pc_src   (pc_src),
        .mar_addr (mar_addr),
        .mar_src  (mar_src)
    );

    // Expected result, from the requirement text.
    function automatic exp_t model(logic [15:0] i, logic [15:0] pc,
                                   logic [15:0] b, logic [15:0] bus, logic [2:0] cc);
        exp_t e;
        logic [15:0] s6, s9, s11;
        s6  = {{10{i[5]}}, i[5:0]};
        s9  = {{7{i[8]}}, i[8:0]};
        s11 = {{5{i[10]}}, i[10:0]};
        e.ea = '0; e.pcn = pc; e.pcs = 2'b00; e.mar = '0; e.mars = 1'b0;
        e.chk_ea = 1'b0; e.chk_mar = 1'b0; e.note = "";
        case (i[15:12])
            4'b0000: begin // R6
                e.tag = "R6"; e.ea = pc + s9; e.chk_ea = 1; e.chk_mar = 1; e.mar = e.ea;
                if ((i[11:9] & cc) != 3'b000) begin e.pcs = 2'b01; e.pcn = e.ea; end
            end
            4'b0010, 4'b0011, 4'b1010, 4'b1011, 4'b1110: begin // R1
                e.tag = "R1"; e.ea = pc + s9; e.chk_ea = 1; e.chk_mar = 1; e.mar = e.ea;
            end
            4'b0110, 4'b0111: begin // R2
                e.tag = "R2"; e.ea = b + s6; e.chk_ea = 1; e.chk_mar = 1; e.mar = e.ea;
            end
            4'b0100: begin // R3 / R4
                e.tag = i[11] ? "R3" : "R4";
                e.ea = i[11] ? pc + s11 : b; e.chk_ea = 1; e.chk_mar = 1; e.mar = e.ea;
                e.pcs = 2'b01; e.pcn = e.ea;
            end
            4'b1100: begin // R4
                e.tag = "R4"; e.ea = b; e.chk_ea = 1; e.chk_mar = 1; e.mar = e.ea;
                e.pcs = 2'b01; e.pcn = b;
            end
            4'b1111: begin // R5
                e.tag = "R5"; e.pcs = 2'b10; e.pcn = bus;
                e.mars = 1'b1; e.mar = {8'h00, i[7:0]}; e.chk_mar = 1;
            end
            4'b1000: begin // R7
                e.tag = "R7"; e.pcs = 2'b10; e.pcn = bus;
            end
            default: e.tag = "R8";
        endcase
        return e;
    endfunction

    // Driver: apply one vector at the falling edge and queue its expectation.
    task automatic apply(logic [15:0] i, logic [15:0] pc, logic [15:0] b,
                         logic [15:0] bus, logic [2:0] cc, string note);
        exp_t e;
        @(negedge clk);
        instr = i; pc_inc = pc; base_val = b; bus_val = bus; cc_nzp = cc;
        e = model(i, pc, b, bus, cc);
        e.note = note;
        sb.push_back(e);
    endtask

    // Monitor: compare at the rising edge, half a period after the drive.
    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            bit   bad;
            e = sb.pop_front();
            bad = 1'b0;
            n_vec++;
            if (e.chk_ea && ea_sum !== e.ea) begin
                $display("FAIL %s %s ea_sum got %h exp %h", e.tag, e.note, ea_sum, e.ea); bad = 1;
            end
            if (pc_next !== e.pcn) begin
                $display("FAIL %s %s pc_next got %h exp %h", e.tag, e.note, pc_next, e.pcn); bad = 1;
            end
            if (pc_src !== e.pcs) begin
                $display("FAIL %s %s pc_src got %b exp %b", e.tag, e.note, pc_src, e.pcs); bad = 1;
            end
            if (e.chk_mar && mar_addr !== e.mar) begin
                $display("FAIL %s %s mar_addr got %h exp %h", e.tag, e.note, mar_addr, e.mar); bad = 1;
            end
            if (mar_src !== e.mars) begin // R10
                $display("FAIL R10 %s mar_src got %b exp %b", e.note, mar_src, e.mars); bad = 1;
            end
            if (bad) n_bad++;
        end
    end

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired got hang exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rnd;
        // Quiet vector: all-zero word is a branch with no condition (R6).
        apply(16'h0000, 16'h0000, 16'h0000, 16'h0000, 3'b000, "reset-like zero word");
        // R6: taken / not taken / empty condition with all flags.
        apply(16'b0000_100_111111111, 16'h3000, 16'h0, 16'h0, 3'b100, "BRn taken -1");
        apply(16'b0000_010_000000101, 16'h3000, 16'h0, 16'h0, 3'b100, "BRz not taken");
        apply(16'b0000_000_000000101, 16'h3000, 16'h0, 16'h0, 3'b111, "BR empty cond");
        for (int c = 1; c < 8; c++)
            for (int f = 0; f < 3; f++)
                apply({4'b0000, c[2:0], 9'h010}, 16'h4000, 16'h0, 16'h0, 3'b001 << f, "R6 cond sweep");
        // R1: PC-relative reach limits and each user opcode.
        apply(16'b0010_001_011111111, 16'h3000, 16'h0, 16'h0, 3'b0, "LD +255");
        apply(16'b0010_001_100000000, 16'h3000, 16'h0, 16'h0, 3'b0, "LD -256");
        apply(16'b0011_010_000001000, 16'h2081, 16'h0, 16'h0, 3'b0, "ST +8");
        apply(16'b1010_010_111000011, 16'h2081, 16'h0, 16'h0, 3'b0, "LDI -61");
        apply(16'b1011_011_000000001, 16'h2081, 16'h0, 16'h0, 3'b0, "STI +1");
        apply(16'b1110_101_111111101, 16'h3001, 16'h0, 16'h0, 3'b0, "LEA -3");
        // R2: base plus 6-bit offset limits.
        apply(16'b0110_001_110_001100, 16'h1111, 16'h2035, 16'h0, 3'b0, "LDR +12");
        apply(16'b0110_001_110_011111, 16'h1111, 16'h2035, 16'h0, 3'b0, "LDR +31");
        apply(16'b0111_010_100_100000, 16'h1111, 16'h2035, 16'h0, 3'b0, "STR -32");
        // R3: 11-bit PC-relative call.
        apply(16'b0100_1_01111111111, 16'h5000, 16'h0, 16'h0, 3'b0, "JSR +1023");
        apply(16'b0100_1_10000000000, 16'h5000, 16'h0, 16'h0, 3'b0, "JSR -1024");
        // R4: register jump, register call, return through R7.
        apply(16'b1100_000_101_000000, 16'h5000, 16'h3500, 16'h0, 3'b0, "JMP base");
        apply(16'b1100_000_111_000000, 16'h5000, 16'h8123, 16'h0, 3'b0, "RET base");
        apply(16'b0100_0_00_011_000000, 16'h5000, 16'hABCD, 16'h0, 3'b0, "JSRR base");
        // R5: trap vector and bus-supplied PC.
        apply(16'hF023, 16'h3005, 16'h0, 16'h0400, 3'b0, "TRAP x23");
        apply(16'hF0FF, 16'h3005, 16'h0, 16'hBEEF, 3'b0, "TRAP xFF");
        // R7: return from interrupt takes the bus word.
        apply(16'h8000, 16'h3005, 16'h0, 16'h1234, 3'b0, "RTI");
        // R8: operate and reserved opcodes keep the incremented PC.
        apply(16'b0001_011_010_000101, 16'h3100, 16'h7777, 16'h9999, 3'b111, "ADD");
        apply(16'b0101_010_010_1_00000, 16'h3100, 16'h7777, 16'h9999, 3'b111, "AND");
        apply(16'b1001_011_101_111111, 16'h3100, 16'h7777, 16'h9999, 3'b111, "NOT");
        apply(16'hD123, 16'h3100, 16'h7777, 16'h9999, 3'b111, "reserved");
        // R9: wrap-around in every adder use.
        apply(16'b0010_000_000000101, 16'hFFFF, 16'h0, 16'h0, 3'b0, "R9 LD wrap up");
        apply(16'b0100_1_11111111110, 16'h0001, 16'h0, 16'h0, 3'b0, "R9 JSR wrap down");
        apply(16'b0110_000_001_011111, 16'h0, 16'hFFF0, 16'h0, 3'b0, "R9 LDR wrap up");
        apply(16'b0000_111_100000000, 16'h0010, 16'h0, 16'h0, 3'b010, "R9 BR wrap down");
        // Random vectors over all opcodes (every requirement by tag).
        rnd = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a, p, b, u;
            rnd = rnd ^ (rnd << 7); rnd = rnd ^ (rnd >> 9); rnd = rnd ^ (rnd << 8); a = rnd;
            rnd = rnd ^ (rnd << 7); rnd = rnd ^ (rnd >> 9); rnd = rnd ^ (rnd << 8); p = rnd;
            rnd = rnd ^ (rnd << 7); rnd = rnd ^ (rnd >> 9); rnd = rnd ^ (rnd << 8); b = rnd;
            rnd = rnd ^ (rnd << 7); rnd = rnd ^ (rnd >> 9); rnd = rnd ^ (rnd << 8); u = rnd;
            apply(a, p, b, u, 3'b001 << (u[1:0] % 3), "random");
        end
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule